// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer

This block is a register-mapped timer bank. One shared prescaler divides the system clock into a tick. That tick drives up to seven independent down-counting channels. Software programs each channel with a reload value and a control word. A channel then either counts once and stops, or reloads itself on every underflow to give a periodic event. On underflow a channel can raise a pending flag and a one-clock interrupt pulse on its own output line.

The register port is a flat array of 32-bit words. A write strobe, a word address and write data act in the cycle they are presented. Read data is a combinational function of the word address. Words 0 to 3 are the common registers: scaler value, scaler reload, configuration and latch configuration. Channel n occupies words 4+4n to 7+4n, holding its counter, reload, control and latch words in that order. The latch words are plain holding registers.

Each channel is a two-state machine. In STOPPED the counter holds. In COUNTING the counter steps on scaler ticks. The transitions are:
- start: STOPPED to COUNTING, on a control write with the enable bit set.
- stop: COUNTING to STOPPED, on a control write with the enable bit clear.
- expire: COUNTING to STOPPED, on an underflow while the restart bit is clear.

Top module: `tmr_bank`

## Requirements
- R1: The word map is as follows. Word 0 is the scaler value, word 1 the scaler reload, word 2 the configuration and word 3 the latch configuration. Channel n uses words 4+4n (counter), 5+4n (reload), 6+4n (control) and 7+4n (latch). The reload, latch and latch-configuration words read back as written, truncated to their widths.
- R2: The scaler value decrements by one each clock. In a clock where it is zero it emits one tick and reloads from the scaler reload word, so a reload of P-1 gives one tick every P clocks. A write to word 0 sets the scaler value.
- R3: Only NCH channels exist (parameter, 1 to 7). Words of channels at or beyond NCH read as zero, and writes to them have no effect.
- R4: The configuration word is read-only and reads as follows. Bits 2:0 hold NCH. Bits 7:3 hold the IRQ_BASE parameter. Bit 8 is 1, meaning one interrupt line per channel. All other bits are 0. Writes to it are ignored.
- R5: Control word bits are: 0 enable, 1 restart, 3 interrupt enable, 4 pending and 7 chain flag. Bits 0, 1, 3 and 7 read back as written. Bit 2 is a load command that always reads 0. Writing control with bit 2 set copies the reload word into the counter.
- R6: While enabled, the counter decreases by one on each scaler tick. A write to the channel's counter or control word takes precedence, and any tick in that clock is dropped for that channel.
- R7: An underflow is a counted tick that finds the counter at 0. If the restart bit is set, the counter takes the reload value, so a reload of R-1 underflows once every R ticks. If the restart bit is clear, the counter becomes all ones and enable clears.
- R8: The pending bit (control bit 4) sets at an underflow when interrupt enable is set. A control write with bit 4 set clears it. A control write with bit 4 clear leaves it unchanged.
- R9: A channel's irq output is high for exactly the clock after an underflow edge at which interrupt enable was set, and low otherwise.
- R10: The enable bit reflects the channel state (1 = COUNTING). A stopped channel neither counts nor raises interrupts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| irq | output | NCH | One-clock interrupt pulse per channel |

## Verification
The bench builds the block with three channels, an 8-bit scaler and 16-bit counters. With these values, an all-ones free-running load, a one-shot expiry and a periodic channel all run within a few hundred clocks. The unused address range above the third channel is also within reach for the absent-channel checks. A behavioural model of the scaler and the channels is compared with the interrupt lines and the read port on every clock. Directed checks cover pulse counts over a fixed window, write-one-to-clear and write-over-tick precedence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 5;
    localparam int MAX_CH = 7;

    localparam int CTL_EN = 0;
    localparam int CTL_RS = 1;
    localparam int CTL_LD = 2;
    localparam int CTL_IE = 3;
    localparam int CTL_IP = 4;
    localparam int CTL_CF = 7;

    localparam logic [1:0] W_CNT = 2'd0;
    localparam logic [1:0] W_RLD = 2'd1;
    localparam logic [1:0] W_CTL = 2'd2;
    localparam logic [1:0] W_LAT = 2'd3;

    localparam logic [1:0] C_SVAL = 2'd0;
    localparam logic [1:0] C_SRLD = 2'd1;
    localparam logic [1:0] C_CFG  = 2'd2;
    localparam logic [1:0] C_LCFG = 2'd3;

    typedef enum logic {
        CH_STOPPED  = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic             wr_rld,
    input  logic [31:0]      wdata,
    output logic [SCL_W-1:0] val,
    output logic [SCL_W-1:0] rld,
    output logic             tick
);
    // R2: tick in the clock where the down-count sits at zero
    assign tick = (val == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
            rld <= '0;
        end else begin
            if (wr_rld) rld <= wdata[SCL_W-1:0];
            if (wr_val)    val <= wdata[SCL_W-1:0];
            else if (tick) val <= rld;
            else           val <= val - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_cnt,
    input  logic        wr_rld,
    input  logic        wr_ctl,
    input  logic        wr_lat,
    input  logic [31:0] wdata,
    output logic [31:0] cnt_rd,
    output logic [31:0] rld_rd,
    output logic [31:0] ctl_rd,
    output logic [31:0] lat_rd,
    output logic        irq,
    output logic        en,
    output logic        ip
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic [31:0]      lat_q;
    logic             rs_q, ie_q, cf_q, ip_q;
    logic             step, uflow;

    // R6: a counter or control write in this clock drops the tick
    assign step  = tick && (state_q == CH_COUNTING) && !wr_cnt && !wr_ctl;
    assign uflow = step && (cnt_q == '0);

    // next-state logic: start, stop, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: begin
                if (wr_ctl && wdata[CTL_EN]) state_d = CH_COUNTING;
            end
            CH_COUNTING: begin
                if (wr_ctl && !wdata[CTL_EN]) state_d = CH_STOPPED;
                else if (uflow && !rs_q)      state_d = CH_STOPPED;
            end
            default: state_d = CH_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
            lat_q <= '0;
            rs_q  <= 1'b0;
            ie_q  <= 1'b0;
            cf_q  <= 1'b0;
            ip_q  <= 1'b0;
        end else begin
            if (wr_rld) rld_q <= wdata[CNT_W-1:0];
            if (wr_lat) lat_q <= wdata;
            if (wr_ctl) begin
                rs_q <= wdata[CTL_RS];
                ie_q <= wdata[CTL_IE];
                cf_q <= wdata[CTL_CF];
            end
            if (wr_cnt)                      cnt_q <= wdata[CNT_W-1:0];
            else if (wr_ctl && wdata[CTL_LD]) cnt_q <= rld_q;
            else if (step) begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                else if (rs_q)   cnt_q <= rld_q;
                else             cnt_q <= '1;
            end
            if (wr_ctl && wdata[CTL_IP]) ip_q <= 1'b0;
            else if (uflow && ie_q)      ip_q <= 1'b1;
        end
    end

    // output process: one-clock interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= uflow && ie_q;
    end

    assign en     = (state_q == CH_COUNTING);
    assign ip     = ip_q;
    assign cnt_rd = 32'(cnt_q);
    assign rld_rd = 32'(rld_q);
    assign lat_rd = lat_q;
    assign ctl_rd = {24'd0, cf_q, 2'b00, ip_q, ie_q, 1'b0, rs_q, en};
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int SCL_W    = 16,
    parameter int CNT_W    = 32,
    parameter int IRQ_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCH-1:0]    irq
);
    localparam logic [31:0] CFG_WORD =
        {20'd0, 3'b000, 1'b1, 5'(IRQ_BASE), 3'(NCH)};

    logic [SCL_W-1:0] scl_val, scl_rld;
    logic             scl_tick;
    logic [31:0]      lcfg_q;
    logic [NCH-1:0]   ch_en, ch_ip;
    logic [31:0]      cnt_rd [NCH];
    logic [31:0]      rld_rd [NCH];
    logic [31:0]      ctl_rd [NCH];
    logic [31:0]      lat_rd [NCH];
    logic             common_hit;

    assign common_hit = (addr[4:2] == 3'd0);

    tmr_prescaler #(.SCL_W(SCL_W)) u_scl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (wr_en && common_hit && addr[1:0] == C_SVAL),
        .wr_rld (wr_en && common_hit && addr[1:0] == C_SRLD),
        .wdata  (wdata),
        .val    (scl_val),
        .rld    (scl_rld),
        .tick   (scl_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lcfg_q <= '0;
        else if (wr_en && common_hit && addr[1:0] == C_LCFG) lcfg_q <= wdata;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (addr[4:2] == 3'(i + 1));
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (scl_tick),
            .wr_cnt (hit && addr[1:0] == W_CNT),
            .wr_rld (hit && addr[1:0] == W_RLD),
            .wr_ctl (hit && addr[1:0] == W_CTL),
            .wr_lat (hit && addr[1:0] == W_LAT),
            .wdata  (wdata),
            .cnt_rd (cnt_rd[i]),
            .rld_rd (rld_rd[i]),
            .ctl_rd (ctl_rd[i]),
            .lat_rd (lat_rd[i]),
            .irq    (irq[i]),
            .en     (ch_en[i]),
            .ip     (ch_ip[i])
        );
    end

    // read mux; absent channels read zero
    always_comb begin
        rdata = '0;
        if (common_hit) begin
            unique case (addr[1:0])
                C_SVAL:  rdata = 32'(scl_val);
                C_SRLD:  rdata = 32'(scl_rld);
                C_CFG:   rdata = CFG_WORD;
                default: rdata = lcfg_q;
            endcase
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr[4:2] == 3'(i + 1)) begin
                    unique case (addr[1:0])
                        W_CNT:   rdata = cnt_rd[i];
                        W_RLD:   rdata = rld_rd[i];
                        W_CTL:   rdata = ctl_rd[i];
                        default: rdata = lat_rd[i];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NCH   = 4,
    parameter int SCL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [4:0]       addr,
    input logic [31:0]      rdata,
    input logic [NCH-1:0]   irq,
    input logic [NCH-1:0]   ch_en,
    input logic [NCH-1:0]   ch_ip,
    input logic             scl_tick,
    input logic [SCL_W-1:0] scl_val,
    input logic [SCL_W-1:0] scl_rld
);
    assert_scaler_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_tick && !(wr_en && addr == 5'd0)) |=> (scl_val == $past(scl_rld)));

    assert_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd2 && $past(addr) == 5'd2) |-> $stable(rdata));

    assert_load_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[4:2] != 3'd0 && addr[1:0] == 2'd2) |-> (rdata[2] == 1'b0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_irq_sets_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ch_ip[i]);

        assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(scl_tick));

        assert_enable_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_en[i]) |-> ($past(wr_en) || $past(scl_tick)));
    end
endmodule

bind tmr_bank tmr_checker #(.NCH(NCH), .SCL_W(SCL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .ch_en    (ch_en),
    .ch_ip    (ch_ip),
    .scl_tick (scl_tick),
    .scl_val  (scl_val),
    .scl_rld  (scl_rld)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    localparam int NCH = 3;
    localparam int SW  = 8;
    localparam int CW  = 16;
    localparam int IB  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [4:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int failures = 0;
    int irq0_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_bank #(.NCH(NCH), .SCL_W(SW), .CNT_W(CW), .IRQ_BASE(IB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [SW-1:0] m_sv, m_srl;
    logic [31:0]   m_lcfg;
    logic [CW-1:0] m_cnt [NCH];
    logic [CW-1:0] m_rld [NCH];
    logic [31:0]   m_lat [NCH];
    bit            m_en [NCH], m_rs [NCH], m_ie [NCH], m_ip [NCH], m_cf [NCH], m_irq [NCH];
    bit            m_tick;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sv = '0; m_srl = '0; m_lcfg = '0;
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i] = '0; m_rld[i] = '0; m_lat[i] = '0;
                m_en[i] = 0; m_rs[i] = 0; m_ie[i] = 0; m_ip[i] = 0; m_cf[i] = 0; m_irq[i] = 0;
            end
        end else begin
            m_tick = (m_sv == 0);
            if (wr_en && addr == 5'd0) m_sv = wdata[SW-1:0];
            else if (m_tick)           m_sv = m_srl;
            else                       m_sv = m_sv - 1;
            if (wr_en && addr == 5'd1) m_srl = wdata[SW-1:0];
            if (wr_en && addr == 5'd3) m_lcfg = wdata;
            for (int i = 0; i < NCH; i++) begin
                int b;
                b = 4 + 4 * i;
                m_irq[i] = 0;
                if (wr_en && addr == b) m_cnt[i] = wdata[CW-1:0];
                else if (wr_en && addr == b + 2) begin
                    m_en[i] = wdata[0]; m_rs[i] = wdata[1];
                    m_ie[i] = wdata[3]; m_cf[i] = wdata[7];
                    if (wdata[4]) m_ip[i] = 0;
                    if (wdata[2]) m_cnt[i] = m_rld[i];
                end else if (m_tick && m_en[i]) begin
                    if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
                    else begin
                        if (m_ie[i]) begin m_irq[i] = 1; m_ip[i] = 1; end
                        if (m_rs[i]) m_cnt[i] = m_rld[i];
                        else begin m_cnt[i] = '1; m_en[i] = 0; end
                    end
                end
                if (wr_en && addr == b + 1) m_rld[i] = wdata[CW-1:0];
                if (wr_en && addr == b + 3) m_lat[i] = wdata;
            end
        end
    end

    function automatic logic [31:0] m_read(logic [4:0] a);
        int c;
        if (a[4:2] == 0) begin
            case (a[1:0])
                2'd0: return 32'(m_sv);
                2'd1: return 32'(m_srl);
                2'd2: return 32'(NCH) | (32'(IB) << 3) | 32'h100;
                default: return m_lcfg;
            endcase
        end
        c = int'(a[4:2]) - 1;
        if (c >= NCH) return 32'd0;
        case (a[1:0])
            2'd0: return 32'(m_cnt[c]);
            2'd1: return 32'(m_rld[c]);
            2'd2: return {24'd0, m_cf[c], 2'b00, m_ip[c], m_ie[c], 1'b0, m_rs[c], m_en[c]};
            default: return m_lat[c];
        endcase
    endfunction

    function automatic string tag_for(logic [4:0] a);
        if (a[4:2] == 0) begin
            case (a[1:0])
                2'd2: return "R4 config";
                2'd3: return "R1 latch config";
                default: return "R2 scaler";
            endcase
        end
        if (int'(a[4:2]) > NCH) return "R3 absent channel";
        case (a[1:0])
            2'd0: return "R6 counter";
            2'd1: return "R1 reload";
            2'd2: return "R5 control";
            default: return "R1 latch";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock and compare with the model on the falling edge
    task automatic cyc();
        @(negedge clk);
        for (int i = 0; i < NCH; i++)
            chk(32'(irq[i]), 32'(m_irq[i]), $sformatf("R9 irq[%0d]", i));
        chk(rdata, m_read(addr), tag_for(addr));
        if (irq[0]) irq0_seen++;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        cyc();
        chk(rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(5'd6, 32'h0, "R10 reset control");
        chk(32'(irq), 32'h0, "R9 reset irq");
        rd(5'd2, 32'h143, "R4 config after reset");

        wr(5'd1, 32'd3);                    // P = 4
        chk(rdata, 32'd3, "R2 scaler reload readback");
        wr(5'd5, 32'd2);                    // ch0 reload R-1 = 2
        wr(5'd6, 32'h0F);                   // ld, rs, ie, en
        wr(5'd9, 32'd5);                    // ch1 one-shot
        wr(5'd10, 32'h0D);                  // ld, ie, en
        addr = 5'd4;
        idle(12);
        irq0_seen = 0;
        idle(48);
        chk(32'(irq0_seen), 32'd4, "R7 periodic underflow count");
        rd(5'd10, 32'h18, "R7 one-shot expired, R8 pending");
        rd(5'd8, 32'h0000FFFF, "R7 one-shot counter all ones");
        rd(5'd6, 32'h1B, "R5 load bit reads zero");

        wr(5'd10, 32'h08);
        chk(rdata, 32'h18, "R8 write 0 keeps pending");
        wr(5'd10, 32'h18);
        chk(rdata, 32'h08, "R8 write 1 clears pending");

        wr(5'd13, 32'hFFFF);
        chk(rdata, 32'hFFFF, "R1 reload readback");
        wr(5'd14, 32'h07);                  // free-running
        addr = 5'd12;
        idle(20);
        wr(5'd14, 32'h83);
        chk(rdata, 32'h83, "R5 chain flag readback");
        wr(5'd12, 32'h100);
        chk(rdata, 32'h100, "R6 counter write beats tick");
        idle(12);

        wr(5'd2, 32'hFFFFFFFF);
        chk(rdata, 32'h143, "R4 config write ignored");
        wr(5'd3, 32'hA5A5);
        chk(rdata, 32'hA5A5, "R1 latch config readback");
        wr(5'd7, 32'hDEADBEEF);
        chk(rdata, 32'hDEADBEEF, "R1 latch readback");
        wr(5'd16, 32'h1234);
        chk(rdata, 32'h0, "R3 absent channel write ignored");
        rd(5'd22, 32'h0, "R3 absent channel reads zero");
        wr(5'd0, 32'h120);
        chk(rdata, 32'h20, "R2 scaler value write");

        wr(5'd6, 32'h18);                   // stop ch0, clear pending
        addr = 5'd4;
        irq0_seen = 0;
        idle(30);
        chk(32'(irq0_seen), 32'd0, "R10 stopped channel silent");
        rd(5'd6, 32'h08, "R10 stopped state readback");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule